// File: doc/BRIEF.md
# Multi-format audio serial port receiver

This block takes stereo PCM from a three-wire serial link (bit clock, frame sync, data) and turns each sample into a parallel word of up to 24 bits. A 3-bit format input selects how the frame sync and data are laid out. In the master format the block generates the bit clock and the frame sync itself from the master clock. In every other format these two lines are inputs that must be derived from the master clock. Everything runs in the master-clock domain: the serial lines are registered once and the bit clock is edge-detected, so the bit clock must be no faster than a quarter of the master clock. Data is always taken on the rising bit-clock edge.

Each finished sample leaves the block on a valid/ready stream. It carries the word left-aligned to 24 bits, a left/right tag, and the three side-channel bits (channel status, user, validity) captured near the start of that sample. The serial source cannot be stalled, so back-pressure is limited. A word that has not been taken is held stable for as long as ready stays low. When the next sample completes first, the held word is replaced and out_valid stays high. A separate monitor counts master-clock cycles between active frame-sync edges. It pulses `resync` when the spacing between two such edges moves by the tolerance or more against the previous spacing.

After reset the first frame-sync edge only aligns the port. The first word is delivered at the second active edge, so a partial sample is never emitted. The format input may change only while reset is held.

Top module: `audio_sport_rx`

## Requirements
- R1: While reset is held and right after it is released, out_valid and resync are 0. sck_oe is 0 for any format code other than 0.
- R2: With format code 0, sck_oe is 1. sck_out has a period of 2 master clocks and makes exactly 32 rising edges per fsync_out half. fsync_out changes only as sck_out falls, and fsync_out high marks left. Words are taken from sdata in the same way as with code 1.
- R3: Code 1 (left/right). Each level change of fsync starts a sample, fsync high is left, and data is MSB first from the first bit after the change. Bits past the 24th are ignored. When fewer than 24 bits carry data, the lower positions come out 0.
- R4: Code 2 (word sync). Only a rising fsync edge starts a sample, and data is MSB first from that bit. Samples alternate left, right, starting with left after reset.
- R5: Code 4 (I2S-like). Every fsync change starts a sample, but the MSB arrives one bit later. fsync low is left.
- R6: Codes 5 and 6 (LSB-justified). The word is the last 16 (code 5) or 18 (code 6) bits before the fsync change, MSB first. It is output left-aligned with the bits below it 0. fsync high is left.
- R7: Code 7 (MSB-last). The word is the last 24 bits before the fsync change, sent LSB first. Shorter words are sent with zeros in the top positions, and fsync high is left.
- R8: C, U and V are captured on the first bit of a sample, or on the second bit for code 4. They are delivered with that sample's word on out_c, out_u and out_v.
- R9: Code 3 is reserved and never raises out_valid.
- R10: A word stays on the stream until out_valid and out_ready are both high in the same cycle. A newer word replaces one that has not been taken. No word is output for the sample in progress when the first active fsync edge after reset arrives.
- R11: resync pulses for one cycle when the spacing in master clocks between two successive active fsync edges differs by 4 or more from the spacing before it. A difference of less than 4 gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mck | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Serial format code (0 master, 1 left/right, 2 word sync, 3 reserved, 4 I2S-like, 5 LSB-justified 16, 6 LSB-justified 18, 7 MSB-last) |
| sck_in | input | 1 | Bit clock from the source (formats 1 to 7) |
| fsync_in | input | 1 | Frame sync from the source (formats 1 to 7) |
| sdata | input | 1 | Serial audio data |
| c_in | input | 1 | Serial channel-status bit |
| u_in | input | 1 | Serial user bit |
| v_in | input | 1 | Serial validity bit |
| sck_out | output | 1 | Generated bit clock (format 0) |
| fsync_out | output | 1 | Generated frame sync (format 0) |
| sck_oe | output | 1 | High when the block drives the bit clock and frame sync |
| out_valid | output | 1 | Stream valid |
| out_ready | input | 1 | Stream ready |
| out_data | output | 24 | Sample word, left-aligned |
| out_right | output | 1 | 1 for the right channel, 0 for the left |
| out_c | output | 1 | Channel-status bit of this sample |
| out_u | output | 1 | User bit of this sample |
| out_v | output | 1 | Validity bit of this sample |
| resync | output | 1 | One-cycle pulse on a frame-sync slip |

## Verification
Each input format gets a run of pseudo-random words, with the side-channel pins driven to the inverse of their values on every bit that is not the sampling bit. Wrong bit positions, a wrong MSB offset or a wrong capture bit therefore show up as data or C/U/V miscompares. Runs with 16, 20 and 24 data bits separate trailing-zero padding from bits that leak into unused positions. LSB-justified and MSB-last runs separate data aligned to the end of a slot from data aligned to its start. Alternating channel levels, together with the opposite polarity of the I2S-like format, check the left/right tag. Separate runs stretch one slot by 8 and by 2 master clocks, hold ready low across a whole run, use the reserved code, and run the master format. These tell the slip threshold, the overwrite rule, the suppression of strobes and the generated clocking apart.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [2:0] {
    FMT_MASTER = 3'd0,
    FMT_LR     = 3'd1,
    FMT_WSYNC  = 3'd2,
    FMT_RSVD   = 3'd3,
    FMT_I2S    = 3'd4,
    FMT_RJ16   = 3'd5,
    FMT_RJ18   = 3'd6,
    FMT_MSBL   = 3'd7
  } fmt_e;
endpackage

// File: rtl/sport_clkgen.sv
module sport_clkgen #(
  parameter int SLOT_BITS = 32
) (
  input  logic mck,
  input  logic rst_n,
  input  logic en,
  output logic sck,
  output logic fs
);
  localparam int DIV_W = $clog2(4 * SLOT_BITS);
  logic [DIV_W-1:0] div;

  always_ff @(posedge mck or negedge rst_n) begin
    if (!rst_n)   div <= '0;
    else if (!en) div <= '0;
    else          div <= div + 1'b1;
  end

  assign sck = en & div[0];
  assign fs  = en & ~div[DIV_W-1];
endmodule

// File: rtl/sport_deser.sv
module sport_deser
  import sport_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int BCNT_W = 6
) (
  input  logic              mck,
  input  logic              rst_n,
  input  fmt_e              fmt,
  input  logic              bit_evt,
  input  logic              fs,
  input  logic              d,
  input  logic [2:0]        cuv,
  output logic              stb,
  output logic [WORD_W-1:0] word,
  output logic              right,
  output logic [2:0]        word_cuv
);
  logic              primed, fs_prev, armed, ch_ws;
  logic [BCNT_W-1:0] bitcnt, kidx;
  logic [WORD_W-1:0] sr, top_bit;
  logic [2:0]        cuv_cur;
  logic              is_ws, is_i2s, is_rj, is_ml, is_shift, edge_hit;

  function automatic logic [WORD_W-1:0] pack_word(fmt_e f, logic [WORD_W-1:0] s);
    case (f)
      FMT_RJ16: pack_word = {s[15:0], {(WORD_W-16){1'b0}}};
      FMT_RJ18: pack_word = {s[17:0], {(WORD_W-18){1'b0}}};
      default:  pack_word = s;
    endcase
  endfunction

  always_comb begin
    is_ws    = (fmt == FMT_WSYNC);
    is_i2s   = (fmt == FMT_I2S);
    is_rj    = (fmt == FMT_RJ16) || (fmt == FMT_RJ18);
    is_ml    = (fmt == FMT_MSBL);
    is_shift = is_rj || is_ml;
    edge_hit = primed && (fmt != FMT_RSVD) &&
               (is_ws ? (fs && !fs_prev) : (fs != fs_prev));
    kidx     = is_i2s ? bitcnt - 1'b1 : bitcnt;
    top_bit  = {d, {(WORD_W-1){1'b0}}};
  end

  always_ff @(posedge mck or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0; fs_prev <= 1'b0; armed <= 1'b0; ch_ws <= 1'b0;
      bitcnt <= '0; sr <= '0; cuv_cur <= '0;
      stb <= 1'b0; word <= '0; right <= 1'b0; word_cuv <= '0;
    end else begin
      stb <= 1'b0;
      if (bit_evt) begin
        primed  <= 1'b1;
        fs_prev <= fs;
        if (is_shift) sr <= is_ml ? {d, sr[WORD_W-1:1]} : {sr[WORD_W-2:0], d};
        if (edge_hit) begin
          armed  <= 1'b1;
          bitcnt <= BCNT_W'(1);
          if (armed) begin
            stb      <= 1'b1;
            word     <= pack_word(fmt, sr);
            word_cuv <= cuv_cur;
            right    <= is_ws ? ch_ws : (is_i2s ? fs_prev : !fs_prev);
            if (is_ws) ch_ws <= !ch_ws;
          end
          if (!is_i2s)  cuv_cur <= cuv;
          if (!is_shift) sr <= is_i2s ? '0 : top_bit;
        end else begin
          if (bitcnt != '1) bitcnt <= bitcnt + 1'b1;
          if (is_i2s && bitcnt == BCNT_W'(1)) cuv_cur <= cuv;
          if (!is_shift) sr <= sr | (top_bit >> kidx);
        end
      end
    end
  end
endmodule

// File: rtl/sport_slip.sv
module sport_slip
  import sport_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int SLIP_TOL = 4
) (
  input  logic mck,
  input  logic rst_n,
  input  fmt_e fmt,
  input  logic fs,
  output logic resync
);
  logic             fs_d, edge_m;
  logic [CNT_W-1:0] cnt, prev, dif;
  logic [1:0]       seen;

  always_comb begin
    edge_m = (fmt != FMT_RSVD) &&
             ((fmt == FMT_WSYNC) ? (fs && !fs_d) : (fs != fs_d));
    dif    = (cnt > prev) ? cnt - prev : prev - cnt;
  end

  always_ff @(posedge mck or negedge rst_n) begin
    if (!rst_n) begin
      fs_d <= 1'b0; cnt <= '0; prev <= '0; seen <= '0; resync <= 1'b0;
    end else begin
      fs_d <= fs;
      if (edge_m) begin
        resync <= (seen == 2'd2) && (dif >= CNT_W'(SLIP_TOL));
        prev   <= cnt;
        cnt    <= CNT_W'(1);
        if (seen != 2'd2) seen <= seen + 1'b1;
      end else begin
        resync <= 1'b0;
        if (cnt != '1) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/audio_sport_rx.sv
module audio_sport_rx
  import sport_pkg::*;
#(
  parameter int WORD_W    = 24,
  parameter int SLOT_BITS = 32,
  parameter int CNT_W     = 10,
  parameter int SLIP_TOL  = 4
) (
  input  logic              mck,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic              sck_in,
  input  logic              fsync_in,
  input  logic              sdata,
  input  logic              c_in,
  input  logic              u_in,
  input  logic              v_in,
  output logic              sck_out,
  output logic              fsync_out,
  output logic              sck_oe,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_right,
  output logic              out_c,
  output logic              out_u,
  output logic              out_v,
  output logic              resync
);
  localparam int BCNT_W = $clog2(SLOT_BITS) + 1;

  fmt_e              fmt;
  logic              gen_sck, gen_fs, sck_sel, fs_sel;
  logic              sck_q, sck_qq, fs_q, sd_q, bit_evt;
  logic [2:0]        cuv_q, word_cuv;
  logic              word_stb, word_right;
  logic [WORD_W-1:0] word;

  assign fmt     = fmt_e'(mode);
  assign sck_oe  = (fmt == FMT_MASTER);
  assign sck_sel = sck_oe ? gen_sck : sck_in;
  assign fs_sel  = sck_oe ? gen_fs  : fsync_in;
  assign sck_out   = gen_sck;
  assign fsync_out = gen_fs;
  assign bit_evt = sck_q & ~sck_qq;

  sport_clkgen #(.SLOT_BITS(SLOT_BITS)) u_gen (
    .mck(mck), .rst_n(rst_n), .en(sck_oe), .sck(gen_sck), .fs(gen_fs));

  always_ff @(posedge mck or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; sck_qq <= 1'b0; fs_q <= 1'b0; sd_q <= 1'b0; cuv_q <= '0;
    end else begin
      sck_q <= sck_sel; sck_qq <= sck_q; fs_q <= fs_sel; sd_q <= sdata;
      cuv_q <= {c_in, u_in, v_in};
    end
  end

  sport_deser #(.WORD_W(WORD_W), .BCNT_W(BCNT_W)) u_deser (
    .mck(mck), .rst_n(rst_n), .fmt(fmt), .bit_evt(bit_evt), .fs(fs_q),
    .d(sd_q), .cuv(cuv_q), .stb(word_stb), .word(word), .right(word_right),
    .word_cuv(word_cuv));

  sport_slip #(.CNT_W(CNT_W), .SLIP_TOL(SLIP_TOL)) u_slip (
    .mck(mck), .rst_n(rst_n), .fmt(fmt), .fs(fs_q), .resync(resync));

  always_ff @(posedge mck or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_data <= '0; out_right <= 1'b0;
      {out_c, out_u, out_v} <= '0;
    end else if (word_stb) begin
      out_valid <= 1'b1; out_data <= word; out_right <= word_right;
      {out_c, out_u, out_v} <= word_cuv;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sport_rx_chk.sv
module sport_rx_chk #(
  parameter int WORD_W = 24
) (
  input logic              mck,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              word_stb,
  input logic              sck_oe,
  input logic              sck_out,
  input logic              fsync_out,
  input logic              fs_sel,
  input logic              resync
);
  assert_hold_R10: assert property (@(posedge mck) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_rsvd_quiet_R9: assert property (@(posedge mck) disable iff (!rst_n)
    (mode == 3'd3) |=> !word_stb);

  assert_rj16_pad_R6: assert property (@(posedge mck) disable iff (!rst_n)
    (out_valid && mode == 3'd5) |-> (out_data[7:0] == 8'd0));

  assert_rj18_pad_R6: assert property (@(posedge mck) disable iff (!rst_n)
    (out_valid && mode == 3'd6) |-> (out_data[5:0] == 6'd0));

  assert_fs_on_fall_R2: assert property (@(posedge mck) disable iff (!rst_n)
    (sck_oe && $past(sck_oe) && !$stable(fsync_out)) |-> $fell(sck_out));

  assert_resync_edge_R11: assert property (@(posedge mck) disable iff (!rst_n)
    resync |-> ($past(fs_sel, 2) != $past(fs_sel, 3)));
endmodule

bind audio_sport_rx sport_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .mck(mck), .rst_n(rst_n), .mode(mode), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .word_stb(word_stb),
  .sck_oe(sck_oe), .sck_out(sck_out), .fsync_out(fsync_out),
  .fs_sel(fs_sel), .resync(resync));

// File: tb/tb_audio_sport_rx.sv
`timescale 1ns/1ps
module tb_audio_sport_rx;
  logic mck = 0, rst_n = 0;
  logic [2:0] mode = 3'd1;
  logic sck_in = 0, fsync_in = 0, sdata = 0, c_in = 0, u_in = 0, v_in = 0;
  logic out_ready = 1;
  logic sck_out, fsync_out, sck_oe, out_valid, out_right, out_c, out_u, out_v, resync;
  logic [23:0] out_data;

  int checks = 0, fails = 0;
  logic [23:0] cap_w [64];
  logic        cap_r [64];
  logic [2:0]  cap_cuv [64];
  int cap_n = 0, rs_n = 0;
  logic [23:0] exp_w [16];
  logic [2:0]  exp_cuv [16];
  int half_cnt = 0, last_half = 0, halves = 0;
  logic sck_p = 0, fs_p = 0;

  always #5 mck = ~mck;

  audio_sport_rx dut (.mck(mck), .rst_n(rst_n), .mode(mode), .sck_in(sck_in),
    .fsync_in(fsync_in), .sdata(sdata), .c_in(c_in), .u_in(u_in), .v_in(v_in),
    .sck_out(sck_out), .fsync_out(fsync_out), .sck_oe(sck_oe),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_right(out_right), .out_c(out_c), .out_u(out_u), .out_v(out_v),
    .resync(resync));

  always @(negedge mck) begin
    if (out_valid && out_ready && cap_n < 64) begin
      cap_w[cap_n] <= out_data; cap_r[cap_n] <= out_right;
      cap_cuv[cap_n] <= {out_c, out_u, out_v}; cap_n <= cap_n + 1;
    end
    if (resync) rs_n <= rs_n + 1;
    sck_p <= sck_out; fs_p <= fsync_out;
    if (sck_out && !sck_p) half_cnt <= half_cnt + 1;
    if (fsync_out != fs_p) begin
      last_half <= half_cnt; half_cnt <= 0; halves <= halves + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic do_reset(input logic [2:0] m);
    @(negedge mck);
    rst_n = 0; mode = m; sck_in = 0; fsync_in = 0; sdata = 0;
    repeat (4) @(negedge mck);
    cap_n = 0; rs_n = 0; halves = 0; half_cnt = 0;
    rst_n = 1;
  endtask

  task automatic send_bit(input logic fs, input logic d, input logic [2:0] cuv, input int extra);
    @(negedge mck);
    sck_in = 0; fsync_in = fs; sdata = d; {c_in, u_in, v_in} = cuv;
    repeat (2 + extra) @(negedge mck);
    sck_in = 1;
    @(negedge mck);
  endtask

  function automatic logic [23:0] sent_word(input logic [2:0] m, input logic [23:0] w, input int len);
    case (m)
      3'd5:    sent_word = w & (24'hFFFFFF << 8);
      3'd6:    sent_word = w & (24'hFFFFFF << 6);
      3'd7:    sent_word = w & (24'hFFFFFF >> (24 - len));
      default: sent_word = w & ~(24'hFFFFFF >> len);
    endcase
  endfunction

  task automatic send_slot(input logic [2:0] m, input logic [23:0] w, input int len,
                           input logic left, input logic ws_hi, input logic [2:0] cuv,
                           input int extra);
    logic lvl;
    lvl = (m == 3'd4) ? ~left : left;
    for (int k = 0; k < 32; k++) begin
      logic b, f;
      logic [2:0] cd;
      case (m)
        3'd4:    b = (k >= 1 && k - 1 < len) ? w[24 - k] : 1'b0;
        3'd5:    b = (k >= 16) ? w[39 - k] : 1'b0;
        3'd6:    b = (k >= 14) ? w[37 - k] : 1'b0;
        3'd7:    b = (k >= 8) ? w[k - 8] : 1'b0;
        default: b = (k < len) ? w[23 - k] : 1'b0;
      endcase
      f  = (m == 3'd2) ? (ws_hi && k < 8) : lvl;
      cd = (k == ((m == 3'd4) ? 1 : 0)) ? cuv : ~cuv;
      send_bit(f, b, cd, (k == 31) ? extra : 0);
    end
  endtask

  task automatic run_fmt(input logic [2:0] m, input int len, input int n,
                         input int st_slot, input int st_extra);
    do_reset(m);
    send_slot(m, 24'h0, len, 1'b0, 1'b0, 3'b000, 0);
    for (int i = 0; i < n; i++) begin
      logic [31:0] h;
      h = 32'h9E3779B9 * (i + 1) + {29'd0, m} * 32'h01010101 + len * 32'h77;
      exp_w[i]   = sent_word(m, h[23:0], len);
      exp_cuv[i] = 3'(i + m) ^ 3'b101;
      send_slot(m, exp_w[i], len, (i % 2) == 0, 1'b1, exp_cuv[i],
                (i == st_slot) ? st_extra : 0);
    end
    send_slot(m, 24'h0, len, (n % 2) == 0, 1'b1, 3'b000, 0);
    repeat (20) @(negedge mck);
  endtask

  task automatic check_caps(input string req, input int n);
    chk({req, " word count"}, cap_n, n);
    for (int i = 0; i < n && i < cap_n; i++) begin
      chk({req, " data"}, cap_w[i], exp_w[i]);
      chk({req, " channel tag"}, cap_r[i], (i % 2) == 1);
      chk("R8 side bits", cap_cuv[i], exp_cuv[i]);
    end
    chk("R11 no slip on steady sync", rs_n, 0);
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    mode = 3'd1; rst_n = 0;
    repeat (3) @(negedge mck);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 resync in reset", resync, 0);
    chk("R1 drive off", sck_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge mck);
    chk("R1 valid after reset", out_valid, 0);

    // R3, R4, R5: MSB-first formats at several word lengths
    for (int li = 0; li < 3; li++) begin
      int len;
      len = 16 + 4 * li;
      run_fmt(3'd1, len, 6, -1, 0); check_caps("R3", 6);
      run_fmt(3'd2, len, 6, -1, 0); check_caps("R4", 6);
      run_fmt(3'd4, len, 6, -1, 0); check_caps("R5", 6);
    end
    // R6, R7: end-aligned formats
    run_fmt(3'd5, 24, 6, -1, 0); check_caps("R6 16-bit", 6);
    run_fmt(3'd6, 24, 6, -1, 0); check_caps("R6 18-bit", 6);
    run_fmt(3'd7, 24, 6, -1, 0); check_caps("R7", 6);
    run_fmt(3'd7, 16, 6, -1, 0); check_caps("R7 leading zeros", 6);

    // R9: reserved code
    run_fmt(3'd3, 24, 4, -1, 0);
    chk("R9 reserved words", cap_n, 0);
    chk("R9 reserved valid", out_valid, 0);

    // R11: slip thresholds
    run_fmt(3'd1, 24, 6, 2, 8);
    chk("R11 slip of 8 flagged", rs_n > 0, 1);
    chk("R11 data after slip", cap_n, 6);
    run_fmt(3'd1, 24, 6, 2, 2);
    chk("R11 jitter of 2 ignored", rs_n, 0);

    // R10: back-pressure, held word replaced by newest
    out_ready = 0;
    run_fmt(3'd1, 24, 6, -1, 0);
    chk("R10 nothing taken while not ready", cap_n, 0);
    chk("R10 valid held", out_valid, 1);
    chk("R10 newest word held", out_data, exp_w[5]);
    chk("R10 newest tag held", out_right, 1);
    out_ready = 1;
    repeat (4) @(negedge mck);
    chk("R10 one word after ready", cap_n, 1);
    chk("R10 valid drops after accept", out_valid, 0);

    // R2: master format
    do_reset(3'd0);
    sdata = 1; {c_in, u_in, v_in} = 3'b101;
    repeat (1300) @(negedge mck);
    chk("R2 drive on", sck_oe, 1);
    chk("R2 sck rises per half", last_half, 32);
    chk("R2 halves seen", halves >= 8, 1);
    chk("R2 words delivered", cap_n >= 6, 1);
    for (int i = 0; i < 6 && i < cap_n; i++) begin
      chk("R2 data", cap_w[i], 24'hFFFFFF);
      chk("R2 tag alternates from right", cap_r[i], (i % 2) == 0);
      chk("R8 master side bits", cap_cuv[i], 3'b101);
    end
    sdata = 0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule